// File: doc/BRIEF.md
# Software interrupt level mask

This block keeps a 17-bit software interrupt word and a 4-bit processor priority level, and turns them into one interrupt request line per bit of the word. The line for an ordinary bit is raised only when that bit is set and the bit's index is above the current priority level. The two ends of the word are special: bit 0 is raised by a cycle-counter compare match and bit 16 by a system-counter compare match. Each of those two lines is raised when its bit is set and the level is below a fixed threshold of 14.

Software reaches the block through one write port with four targets, chosen by a 2-bit select: 0 replaces the word, 1 ORs data into it, 2 clears the bits that are set in the data, and 3 loads the priority level from data bits 3:0. Both registers can be read back at any time. Two single-cycle strobes from the timer compare logic each set one of the special bits. When a strobe comes in the same cycle as a write to the word, it is merged into the write result. The request lines are registered. They reflect the register contents one clock later.

Top module: `soft_irq_mask`

## Requirements
- R1: After reset the software word, the priority level and all request lines are zero.
- R2: Request line 0 (or 16) is high one cycle after a state in which word bit 0 (or 16) is set and the priority level is less than 14; otherwise it is low.
- R3: Request line k, for k in 1..15, is high one cycle after a state in which word bit k is set and k is strictly greater than the priority level; otherwise it is low.
- R4: A write with select 0 replaces the word with data bits 16:0; data bits above 16 are ignored.
- R5: A write with select 1 sets the word to its old value OR data bits 16:0.
- R6: A write with select 2 sets the word to its old value AND the complement of data bits 16:0.
- R7: A write with select 3 loads the priority level from data bits 3:0, leaves the word unchanged, and all request lines are re-evaluated against the new level.
- R8: A high on the tick strobe sets word bit 0 and a high on the system-tick strobe sets word bit 16 at the next edge, including in a cycle with a write of any select, where the strobe bit is applied after the write result.
- R9: The read ports show the register values from the edge at which a write or strobe takes effect, and the request lines follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 word, 1 OR into word, 2 clear from word, 3 level |
| wr_data | input | 32 | Write data |
| tick_hit | input | 1 | Cycle-counter compare strobe, sets bit 0 |
| stick_hit | input | 1 | System-counter compare strobe, sets bit 16 |
| rd_soft | output | 17 | Current software word |
| rd_level | output | 4 | Current priority level |
| irq_req | output | 17 | Registered request line per word bit |

## Verification
The hardest case to reach is a timer strobe that arrives in the same cycle as a clear write naming that same bit. Here the strobe has to win, and random stimulus rarely lines the two up. Directed steps force this collision for both special bits. They also walk the level across the threshold of 13 to 14, and across the points where a bit's index equals the level. The random stimulus draws selects, data and strobes from a fixed seed. The bench compares every cycle against its own model, and that model includes the one-cycle delay on the request lines.

// File: rtl/soft_irq_mask.sv
module soft_irq_mask #(
  parameter int SW     = 17,
  parameter int LW     = 4,
  parameter int DW     = 32,
  parameter int THRESH = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          tick_hit,
  input  logic          stick_hit,
  output logic [SW-1:0] rd_soft,
  output logic [LW-1:0] rd_level,
  output logic [SW-1:0] irq_req
);
  localparam int TOP = SW - 1;

  logic [SW-1:0] soft_q, soft_wr, timer_bits, req_next;
  logic [LW-1:0] level_q;
  logic [SW-1:0] wd;

  assign wd = wr_data[SW-1:0];
  assign timer_bits = {stick_hit, {(SW-2){1'b0}}, tick_hit};

  always_comb begin
    soft_wr = soft_q;
    if (wr_en) begin
      case (wr_sel)
        2'd0: soft_wr = wd;
        2'd1: soft_wr = soft_q | wd;
        2'd2: soft_wr = soft_q & ~wd;
        default: soft_wr = soft_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q  <= '0;
      level_q <= '0;
      irq_req <= '0;
    end else begin
      soft_q <= soft_wr | timer_bits;
      if (wr_en && wr_sel == 2'd3) level_q <= wr_data[LW-1:0];
      irq_req <= req_next;
    end
  end

  for (genvar g = 0; g < SW; g++) begin : g_req
    if (g == 0 || g == TOP) begin : g_timer
      assign req_next[g] = soft_q[g] && (int'(level_q) < THRESH);
    end else begin : g_plain
      assign req_next[g] = soft_q[g] && (g > int'(level_q));
    end
  end

  assign rd_soft  = soft_q;
  assign rd_level = level_q;

  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> $past(soft_q[0]) && (int'($past(level_q)) < THRESH));
  // R2
  stick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[TOP] |-> $past(soft_q[TOP]) && (int'($past(level_q)) < THRESH));
  // R5
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> ((soft_q & $past(wd)) == $past(wd)));
  // R6
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !tick_hit && !stick_hit) |=> ((soft_q & $past(wd)) == '0));
  // R7
  level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && !tick_hit && !stick_hit) |=> $stable(soft_q));
  // R8
  tick_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hit |=> soft_q[0]);
  // R8
  stick_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stick_hit |=> soft_q[TOP]);
endmodule

// File: tb/test_soft_irq_mask.sv
module test_soft_irq_mask;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        tick_hit = 1'b0;
  logic        stick_hit = 1'b0;
  logic [16:0] rd_soft, irq_req;
  logic [3:0]  rd_level;

  int total = 0;
  int bad = 0;
  logic [16:0] m_soft = '0;
  logic [3:0]  m_lvl = '0;

  always #(PERIOD/2) clk = ~clk;

  soft_irq_mask i_soft_irq_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_hit(tick_hit), .stick_hit(stick_hit),
    .rd_soft(rd_soft), .rd_level(rd_level), .irq_req(irq_req));

  function automatic logic [16:0] exp_req(logic [16:0] s, logic [3:0] l);
    logic [16:0] r;
    for (int i = 1; i < 16; i++) r[i] = s[i] && (i > int'(l));
    r[0]  = s[0]  && (l < 4'd14);
    r[16] = s[16] && (l < 4'd14);
    return r;
  endfunction

  function automatic logic [16:0] exp_soft(logic [16:0] s, logic en, logic [1:0] sel,
                                           logic [31:0] d, logic tk, logic st);
    logic [16:0] n;
    n = s;
    if (en) begin
      if (sel == 2'd0) n = d[16:0];
      else if (sel == 2'd1) n = s | d[16:0];
      else if (sel == 2'd2) n = s & ~d[16:0];
    end
    n[0]  = n[0] | tk;
    n[16] = n[16] | st;
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic [1:0] sel, logic [31:0] d, logic tk, logic st);
    logic [16:0] er;
    string stag;
    wr_en = en; wr_sel = sel; wr_data = d; tick_hit = tk; stick_hit = st;
    @(posedge clk);
    @(negedge clk);
    er = exp_req(m_soft, m_lvl);
    m_soft = exp_soft(m_soft, en, sel, d, tk, st);
    if (en && sel == 2'd3) m_lvl = d[3:0];
    if (tk || st) stag = "R8";
    else if (!en) stag = "R9";
    else if (sel == 2'd0) stag = "R4";
    else if (sel == 2'd1) stag = "R5";
    else if (sel == 2'd2) stag = "R6";
    else stag = "R7";
    check(stag, 32'(rd_soft), 32'(m_soft));
    check("R7 level", 32'(rd_level), 32'(m_lvl));
    check("R2 special lines", 32'({irq_req[16], irq_req[0]}), 32'({er[16], er[0]}));
    check("R3 ordinary lines", 32'(irq_req[15:1]), 32'(er[15:1]));
    wr_en = 1'b0; tick_hit = 1'b0; stick_hit = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'd1234;
    r = $urandom(seed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 soft", 32'(rd_soft), 0);
    check("R1 level", 32'(rd_level), 0);
    check("R1 irq", 32'(irq_req), 0);

    // R4: upper data bits ignored
    step(1, 2'd0, 32'hFFFE_0005, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    // R2 threshold walk: level 13 then 14, special bits set
    step(1, 2'd0, 32'h1_0001, 0, 0);
    step(1, 2'd3, 32'd13, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    step(1, 2'd3, 32'd14, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    // R3 index equal to level is blocked, one above passes
    step(1, 2'd0, 32'h0_01E0, 0, 0);
    step(1, 2'd3, 32'd6, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    step(1, 2'd3, 32'd15, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    step(1, 2'd3, 32'd0, 0, 0);
    step(0, 2'd0, 0, 0, 0);
    // R8 strobe collides with clear of the same bit
    step(1, 2'd0, 32'h1_FFFF, 0, 0);
    step(1, 2'd2, 32'h1_0001, 1, 1);
    step(1, 2'd2, 32'h1_0001, 0, 0);
    step(1, 2'd0, 32'h0_0000, 1, 0);
    step(1, 2'd1, 32'h0_0100, 0, 1);
    step(1, 2'd3, 32'd2, 1, 1);
    step(0, 2'd0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      logic [1:0] s;
      d = $urandom;
      s = 2'($urandom);
      if (s == 2'd3) d = 32'($urandom % 16);
      step(1'($urandom % 3 != 0), s, d, 1'($urandom % 8 == 0), 1'($urandom % 8 == 0));
    end
    step(0, 2'd0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule